// File: doc/BRIEF.md
# SAR Conversion Sequencer

This block is the digital control for a 14-bit differential successive-approximation converter built on two mirrored charge-redistribution capacitor arrays. While idle it holds the acquisition setup. In that setup both sampling switches ground the comparator-side plates, and every array element is tied to the analog inputs. A convert-start request launches a conversion. The sequencer first opens the sampling switches. It then parks every element on ground and runs one binary-search trial per bit, from the most significant bit down to the least. Each trial reads the comparator decision.

At the end the sequencer restores the acquisition setup and registers the new result code in the same cycle that busy falls. The code therefore always belongs to the latest conversion, with no pipeline delay. The analog core enable is high only while a conversion runs. Every step is paced by the block's own conversion clock, so no serial clock is involved.

Top module: `sar_seq`

## Requirements
- R1: Out of reset and between conversions, both sampling switch outputs are 1 (closed), every bit of the element-on-input vector is 1, both reference vectors are 0, busy and the core enable are 0, and after reset the code is 0.
- R2: A 1 on the convert-start input at a clock edge while busy is 0 starts a conversion, and busy reads 1 from that edge on.
- R3: In the first cycle of a conversion, both sampling switch outputs are 0 while every element is still on the inputs.
- R4: In the second cycle, every element-on-input bit is 0 (the element is grounded) and both reference vectors are 0.
- R5: The trials run from bit NBITS-1 down to bit 0. A trial sets its bit in the reference vector for two cycles, with the first cycle used for settling. The comparator is sampled at the edge that ends the second cycle. A 1 ("input still above") keeps the bit and a 0 clears it. With an ideal comparator, an input of value v converts to code v.
- R6: The negative-array reference vector always equals the positive-array reference vector.
- R7: Busy stays high for exactly 2*NBITS+2 cycles (30 by default). Busy falls on the edge that registers the new code, and the acquisition setup of R1 returns on the same edge.
- R8: During a conversion the code output keeps the result of the previous conversion.
- R9: A convert-start request while busy is 1 has no effect: the conversion keeps its length and result, and no extra conversion follows.
- R10: The core enable output is high exactly while busy is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Internal conversion clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnv_start | input | 1 | Convert-start request, level sampled while idle |
| cmp_above | input | 1 | Comparator decision, 1 = input still above the trial level |
| busy | output | 1 | Conversion in progress |
| core_en | output | 1 | Analog core power enable |
| samp_sw_p | output | 1 | Positive-side sampling switch, 1 = plate grounded |
| samp_sw_n | output | 1 | Negative-side sampling switch, 1 = plate grounded |
| elem_on_in | output | NBITS | Per element: 1 = on analog inputs, 0 = off inputs |
| elem_ref_p | output | NBITS | Positive array, per element: 1 = on reference, 0 = on ground |
| elem_ref_n | output | NBITS | Negative array, per element: 1 = on reference, 0 = on ground |
| code | output | NBITS | Result of the latest completed conversion |

## Verification
The assertions check on every cycle that the idle outputs keep the acquisition setup and that the elements are still on the inputs when the sampling switches open. They also check that the elements leave the inputs on the next cycle, that the two reference vectors match, that the code is frozen while busy, and that the core enable tracks busy. Only the bench scenarios can show three further things: that the binary search reaches the right code across the input range, that busy lasts exactly thirty cycles, and that a mid-conversion request is dropped. The bench's comparator model gives the wrong answer in every settling cycle, so a decision sampled one cycle early yields a wrong code.

// File: rtl/sar_seq.sv
module sar_seq #(
  parameter int NBITS = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cnv_start,
  input  logic             cmp_above,
  output logic             busy,
  output logic             core_en,
  output logic             samp_sw_p,
  output logic             samp_sw_n,
  output logic [NBITS-1:0] elem_on_in,
  output logic [NBITS-1:0] elem_ref_p,
  output logic [NBITS-1:0] elem_ref_n,
  output logic [NBITS-1:0] code
);
  localparam int BW = $clog2(NBITS);
  localparam logic [NBITS-1:0] TOP = {1'b1, {(NBITS-1){1'b0}}};

  typedef enum logic [2:0] {S_ACQ, S_OPEN, S_XFER, S_SETTLE, S_SAMPLE} st_t;

  st_t              st;
  logic [BW-1:0]    bitp;
  logic [NBITS-1:0] trial, kept, next_trial, code_q;
  logic             busy_q;

  always_comb begin
    kept = trial;
    if (!cmp_above) kept[bitp] = 1'b0;
    next_trial = kept | ((NBITS'(1) << bitp) >> 1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_ACQ;
      bitp   <= '0;
      trial  <= '0;
      code_q <= '0;
      busy_q <= 1'b0;
    end else begin
      case (st)
        S_ACQ: if (cnv_start) begin
          st     <= S_OPEN;
          busy_q <= 1'b1;
        end
        S_OPEN: st <= S_XFER;
        S_XFER: begin
          st    <= S_SETTLE;
          bitp  <= BW'(NBITS-1);
          trial <= TOP;
        end
        S_SETTLE: st <= S_SAMPLE;
        S_SAMPLE: begin
          if (bitp == '0) begin
            code_q <= kept;
            trial  <= '0;
            busy_q <= 1'b0;
            st     <= S_ACQ;
          end else begin
            trial <= next_trial;
            bitp  <= bitp - 1'b1;
            st    <= S_SETTLE;
          end
        end
        default: st <= S_ACQ;
      endcase
    end
  end

  assign busy       = busy_q;
  assign core_en    = (st != S_ACQ);
  assign samp_sw_p  = (st == S_ACQ);
  assign samp_sw_n  = (st == S_ACQ);
  assign elem_on_in = {NBITS{st == S_ACQ || st == S_OPEN}};
  assign elem_ref_p = trial;
  assign elem_ref_n = trial;
  assign code       = code_q;
endmodule

// File: rtl/sar_seq_chk.sv
module sar_seq_chk #(
  parameter int NBITS = 14
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cnv_start,
  input logic             busy,
  input logic             core_en,
  input logic             samp_sw_p,
  input logic             samp_sw_n,
  input logic [NBITS-1:0] elem_on_in,
  input logic [NBITS-1:0] elem_ref_p,
  input logic [NBITS-1:0] elem_ref_n,
  input logic [NBITS-1:0] code
);
  assert_idle_setup_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (samp_sw_p && samp_sw_n && (&elem_on_in) && elem_ref_p == '0 && !core_en));

  assert_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && cnv_start) |=> busy);

  assert_open_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(samp_sw_p) |-> (&elem_on_in && !samp_sw_n));

  assert_ground_next_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(samp_sw_p) |=> (elem_on_in == '0));

  assert_mirror_R6: assert property (@(posedge clk) disable iff (!rst_n)
    elem_ref_n == elem_ref_p);

  assert_code_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(code));

  assert_core_en_R10: assert property (@(posedge clk) disable iff (!rst_n)
    core_en == busy);
endmodule

bind sar_seq sar_seq_chk #(.NBITS(NBITS)) u_chk (.*);

// File: tb/sim_sar_seq.sv
`timescale 1ns/1ps
module sim_sar_seq;
  localparam int N = 14;
  logic clk = 1'b0, rst_n = 1'b0, cnv_start = 1'b0, cmp_above = 1'b0;
  logic busy, core_en, samp_sw_p, samp_sw_n;
  logic [N-1:0] elem_on_in, elem_ref_p, elem_ref_n, code;
  logic [N-1:0] vin = '0, last_ref = '0;
  bit mm = 1'b0;
  int n_run = 0, n_fail = 0, cycles = 0;

  always #4 clk = ~clk;

  sar_seq #(.NBITS(N)) u0 (.*);

  always @(negedge clk) begin
    bit settled, ideal;
    settled = (elem_ref_p == last_ref);
    last_ref = elem_ref_p;
    ideal = (vin >= elem_ref_p);
    cmp_above = settled ? ideal : !ideal;
    if (busy && elem_ref_n !== elem_ref_p) mm = 1'b1;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle_chk(input string req);
    chk(samp_sw_p && samp_sw_n && (&elem_on_in) && elem_ref_p == '0 && !busy && !core_en,
        req, {samp_sw_p, samp_sw_n, busy, core_en}, 4'b1100);
  endtask

  task automatic convert(input logic [N-1:0] v, input bit mid);
    int n;
    logic [N-1:0] prev;
    prev = code;
    vin = v;
    mm = 1'b0;
    @(negedge clk) cnv_start = 1'b1;
    @(negedge clk) cnv_start = 1'b0;
    chk(busy && core_en, "R2", {busy, core_en}, 3);
    chk(!samp_sw_p && !samp_sw_n && (&elem_on_in), "R3", {samp_sw_p, samp_sw_n, &elem_on_in}, 1);
    @(negedge clk);
    chk(elem_on_in == '0 && elem_ref_p == '0, "R4", int'(elem_on_in), 0);
    n = 2;
    while (n < 100) begin
      cnv_start = (mid && n == 10);
      @(negedge clk);
      if (!busy) break;
      n++;
      if (n == 15) chk(code == prev, "R8", int'(code), int'(prev));
      if (core_en !== busy) chk(0, "R10", core_en, busy);
    end
    cnv_start = 1'b0;
    chk(n == 2*N+2, mid ? "R9" : "R7", n, 2*N+2);
    chk(code == v, mid ? "R9" : "R5", int'(code), int'(v));
    idle_chk("R7");
    chk(!core_en, "R10", core_en, 0);
    chk(!mm, "R6", mm, 0);
    if (mid) begin
      @(negedge clk);
      chk(!busy, "R9", busy, 0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    idle_chk("R1");
    chk(code == '0, "R1", int'(code), 0);
    rst_n = 1'b1;
    @(negedge clk);
    idle_chk("R1");
    convert(14'h3FFF, 1'b0);
    convert(14'h0000, 1'b0);
    convert(14'h2000, 1'b0);
    convert(14'h1FFF, 1'b0);
    convert(14'h0001, 1'b0);
    convert(14'h2AAA, 1'b0);
    convert(14'h1555, 1'b0);
    convert(14'h0FA3, 1'b1);
    convert(14'h3001, 1'b1);
    for (int v = 0; v < (1 << N); v += 13) convert(N'(v), 1'b0);
    repeat (5) @(negedge clk);
    idle_chk("R1");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      n_fail++;
      n_run++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule